// File: doc/BRIEF.md
# Dual-Channel Tapped Segmented Shift Register

The block holds two independent 64-bit serial shift registers. Each channel has its own clock, serial data input and write-enable. Each chain is split into four 16-bit segments. The last bit of each segment is brought out as a tap.

With write-enable low, a channel works as one long chain:
- each rising edge moves every bit one place along, and the serial input enters bit 1;
- the four taps drive the segment tail bits, with output enable high.

With write-enable high, the tap drivers turn off:
- all four output enables go low, and the tap outputs read zero;
- the external values on the first three taps are steered into the heads of segments 2, 3 and 4, while the serial input still feeds segment 1.

The four segments then fill in parallel, so a full 64-bit load takes 16 clocks instead of 64. A bidirectional bus pin is modelled as a separate input, output and output-enable for each tap.

All stages clear to zero on an active-low asynchronous reset. Parameters give the channel count, the segment count and the segment length.

Top module: `tsr_dual`

## Requirements
- R1: While `rst_ni` is low, every stage of both channels is zero. After release with write-enable low, all taps read 0 and all output enables read 1.
- R2: With `we_i[c]` low, a rising edge of `clk_i[c]` loads `din_i[c]` into bit 1 of channel c. It also moves the tail of segment k into the head of segment k+1, so the whole chain shifts by one.
- R3: With `we_i[c]` low, `tap_o[c*4+k]` equals the last bit of segment k, that is stage 16(k+1), and `tap_oe_o[c*4+k]` is 1.
- R4: With `we_i[c]` high, all four `tap_oe_o` bits of channel c are 0 and all four `tap_o` bits are 0, at any clock level. This includes the stage-64 tap.
- R5: With `we_i[c]` high, a rising edge loads `din_i[c]` into bit 1. It loads `tap_i[c*3+k]` (k = 0..2) into the first bit of segment k+1, that is stages 17, 33 and 49.
- R6: Sixteen rising edges with `we_i[c]` high set all 64 stages. Afterwards, with write-enable low, tap k shows the value that was on the segment-k input at the first of those edges.
- R7: Edges on one channel's clock never change the other channel's taps or stored contents.
- R8: Within a segment, bits 2 to 16 each take the preceding bit on every rising edge, whatever the write-enable level. The stage-64 tap has no input.
- R9: Without a rising edge on `clk_i[c]`, changes on `we_i[c]`, `din_i[c]` or `tap_i` leave the contents of channel c unchanged. This is seen on the taps once write-enable is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NCH | Per-channel shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low clear of all stages |
| din_i | input | NCH | Per-channel serial data into bit 1 |
| we_i | input | NCH | Per-channel write-enable: 1 = parallel segment load with taps released |
| tap_i | input | NCH*(NSEG-1) | External tap values; bit c*(NSEG-1)+k feeds the head of segment k+1 |
| tap_o | output | NCH*NSEG | Tail bit of segment k of channel c at bit c*NSEG+k; 0 when released |
| tap_oe_o | output | NCH*NSEG | Tap drive enable, 1 when the channel is in shift mode |

## Verification
The hardest situation to reach is a channel whose write-enable changes between edges while its own clock stays still and the other clock runs. The reached state is only visible through the taps once write-enable drops again. The stimulus gates each channel clock separately from a common reference. It holds one channel idle while write-enable, data and tap inputs toggle. It then returns write-enable low and compares the taps with a behavioural model. Random per-cycle write-enable in the mixed phase moves data across the segment heads in both modes.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } tsr_mode_e;
endpackage

// File: rtl/tsr_seg.sv
module tsr_seg #(
  parameter int LEN = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           head_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= {q_q[LEN-2:0], head_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/tsr_chan.sv
module tsr_chan
  import tsr_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int SEG_LEN = 16,
  localparam int DEPTH  = NSEG * SEG_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  input  logic             we_i,
  input  logic [NSEG-2:0]  tap_i,
  output logic [NSEG-1:0]  tap_o,
  output logic [NSEG-1:0]  tap_oe_o,
  output logic [DEPTH-1:0] state_o
);
  tsr_mode_e       mode;
  logic [NSEG-1:0] head;
  logic [NSEG-1:0] tail;

  assign mode = tsr_mode_e'(we_i);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_LEN-1:0] q;
    if (s == 0) begin : g_first
      assign head[s] = din_i;
    end else begin : g_link
      // segment head: external tap in load mode, previous tail in shift mode
      assign head[s] = (mode == MODE_LOAD) ? tap_i[s-1] : tail[s-1];
    end
    tsr_seg #(.LEN(SEG_LEN)) u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .head_i (head[s]),
      .q_o    (q)
    );
    assign tail[s] = q[SEG_LEN-1];
    assign state_o[s*SEG_LEN +: SEG_LEN] = q;
  end

  assign tap_oe_o = {NSEG{mode == MODE_SHIFT}};
  assign tap_o    = tail & tap_oe_o;
endmodule

// File: rtl/tsr_dual.sv
module tsr_dual #(
  parameter int NCH     = 2,
  parameter int NSEG    = 4,
  parameter int SEG_LEN = 16,
  localparam int DEPTH  = NSEG * SEG_LEN,
  localparam int NTIN   = NSEG - 1
) (
  input  logic [NCH-1:0]      clk_i,
  input  logic                rst_ni,
  input  logic [NCH-1:0]      din_i,
  input  logic [NCH-1:0]      we_i,
  input  logic [NCH*NTIN-1:0] tap_i,
  output logic [NCH*NSEG-1:0] tap_o,
  output logic [NCH*NSEG-1:0] tap_oe_o
);
  logic [NCH*DEPTH-1:0] state_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tsr_chan #(.NSEG(NSEG), .SEG_LEN(SEG_LEN)) u_chan (
      .clk_i    (clk_i[c]),
      .rst_ni   (rst_ni),
      .din_i    (din_i[c]),
      .we_i     (we_i[c]),
      .tap_i    (tap_i[c*NTIN +: NTIN]),
      .tap_o    (tap_o[c*NSEG +: NSEG]),
      .tap_oe_o (tap_oe_o[c*NSEG +: NSEG]),
      .state_o  (state_w[c*DEPTH +: DEPTH])
    );
  end
endmodule

// File: rtl/tsr_dual_chk.sv
module tsr_dual_chk #(
  parameter int NCH     = 2,
  parameter int NSEG    = 4,
  parameter int SEG_LEN = 16,
  localparam int DEPTH  = NSEG * SEG_LEN,
  localparam int NTIN   = NSEG - 1
) (
  input logic [NCH-1:0]       clk_i,
  input logic                 rst_ni,
  input logic [NCH-1:0]       din_i,
  input logic [NCH-1:0]       we_i,
  input logic [NCH*NTIN-1:0]  tap_i,
  input logic [NCH*NSEG-1:0]  tap_o,
  input logic [NCH*NSEG-1:0]  tap_oe_o,
  input logic [NCH*DEPTH-1:0] state_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int B = c * DEPTH;

    AST_RELEASED_TAPS: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
      we_i[c] |-> (tap_oe_o[c*NSEG +: NSEG] == '0 && tap_o[c*NSEG +: NSEG] == '0)); // R4

    AST_SERIAL_HEAD: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
      1'b1 |=> state_w[B] == $past(din_i[c])); // R2

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int H = B + s * SEG_LEN;

      AST_TAP_VIEW: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
        !we_i[c] |-> (tap_o[c*NSEG+s] == state_w[H+SEG_LEN-1] && tap_oe_o[c*NSEG+s])); // R3

      if (s > 0) begin : g_link
        AST_CHAIN_LINK: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
          !we_i[c] |=> state_w[H] == $past(state_w[H-1])); // R2
        AST_TAP_LOAD: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
          we_i[c] |=> state_w[H] == $past(tap_i[c*NTIN+s-1])); // R5
      end

      for (genvar j = 1; j < SEG_LEN; j++) begin : g_bit
        AST_INNER_SHIFT: assert property (@(posedge clk_i[c]) disable iff (!rst_ni)
          1'b1 |=> state_w[H+j] == $past(state_w[H+j-1])); // R8
      end
    end
  end
endmodule

bind tsr_dual tsr_dual_chk #(.NCH(NCH), .NSEG(NSEG), .SEG_LEN(SEG_LEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .din_i    (din_i),
  .we_i     (we_i),
  .tap_i    (tap_i),
  .tap_o    (tap_o),
  .tap_oe_o (tap_oe_o),
  .state_w  (state_w)
);

// File: tb/sim_tsr_dual.sv
`timescale 1ns/1ps
module sim_tsr_dual;
  localparam int NCH = 2, NSEG = 4, SEG_LEN = 16;
  localparam int DEPTH = NSEG * SEG_LEN, NTIN = NSEG - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_ni = 1'b0;
  logic [NCH-1:0]      en = '0;
  logic [NCH-1:0]      din = '0;
  logic [NCH-1:0]      we = '0;
  logic [NCH*NTIN-1:0] tin = '0;
  logic [NCH-1:0]      ch_clk;
  logic [NCH*NSEG-1:0] tap_o, tap_oe_o;

  assign ch_clk = {NCH{clk}} & en;

  tsr_dual #(.NCH(NCH), .NSEG(NSEG), .SEG_LEN(SEG_LEN)) u0 (
    .clk_i(ch_clk), .rst_ni(rst_ni), .din_i(din), .we_i(we),
    .tap_i(tin), .tap_o(tap_o), .tap_oe_o(tap_oe_o)
  );

  int total = 0, bad = 0, cycles = 0;
  string cur_tag = "R1";
  bit model [NCH][DEPTH];

  // behavioural reference: array indexed by stage number - 1
  always @(posedge clk) begin
    cycles++;
    if (!rst_ni) begin
      foreach (model[c, i]) model[c][i] = 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (en[c]) begin
          bit nxt [DEPTH];
          for (int i = DEPTH-1; i > 0; i--) begin
            if (i % SEG_LEN == 0 && we[c]) nxt[i] = tin[c*NTIN + i/SEG_LEN - 1];
            else                          nxt[i] = model[c][i-1];
          end
          nxt[0] = din[c];
          for (int i = 0; i < DEPTH; i++) model[c][i] = nxt[i];
        end
      end
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic compare();
    for (int c = 0; c < NCH; c++) begin
      logic [NSEG-1:0] exp_t, exp_oe;
      for (int s = 0; s < NSEG; s++) begin
        exp_oe[s] = !we[c];
        exp_t[s]  = we[c] ? 1'b0 : model[c][(s+1)*SEG_LEN-1];
      end
      total++;
      if (tap_oe_o[c*NSEG +: NSEG] !== exp_oe) begin
        bad++;
        $display("FAIL %s ch%0d oe: actual=%b expected=%b", we[c] ? "R4" : "R3",
                 c, tap_oe_o[c*NSEG +: NSEG], exp_oe);
      end
      total++;
      if (tap_o[c*NSEG +: NSEG] !== exp_t) begin
        bad++;
        $display("FAIL %s ch%0d tap: actual=%b expected=%b", we[c] ? "R4" : cur_tag,
                 c, tap_o[c*NSEG +: NSEG], exp_t);
      end
    end
  endtask

  // drive at negedge, edge at posedge, compare at next negedge
  task automatic step(input logic [NCH-1:0] e, input logic [NCH-1:0] w);
    en = e; we = w;
    din = NCH'($urandom);
    tin = (NCH*NTIN)'($urandom);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_tag = "R1"; compare();

    cur_tag = "R2";
    for (int i = 0; i < 80; i++) step('1, '0);

    // parallel load channel 0 while channel 1 shifts
    cur_tag = "R5";
    for (int i = 0; i < 16; i++) step('1, 2'b01);
    cur_tag = "R6";
    en = '0; we = '0; @(negedge clk); compare();
    cur_tag = "R8";
    for (int i = 0; i < 16; i++) step('1, '0);

    cur_tag = "R7";
    for (int i = 0; i < 20; i++) step(2'b01, '0);
    for (int i = 0; i < 20; i++) step(2'b10, 2'b10);

    // no edges: toggle controls and data only
    cur_tag = "R9";
    for (int i = 0; i < 6; i++) step('0, NCH'(i));
    en = '0; we = '0; @(negedge clk); compare();

    cur_tag = "R3";
    for (int i = 0; i < 300; i++) step(NCH'($urandom), NCH'($urandom));
    en = '0; we = '0; @(negedge clk); compare();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule